// File: doc/BRIEF.md
# Source Operand Addressing Decoder

This block sits in the decode stage of a 16-bit processor with sixteen registers. For each instruction it takes the source register number, the two-bit source mode field and the byte/word flag, together with the current contents of that register. From these it works out where the source operand comes from: the register itself, a hardwired constant, memory at a computed address, or the instruction extension word. It also reports whether an extension word has to be fetched, gives the base of the effective address, and gives the post-increment value and register to write back. It does the same on the destination side for the register and indexed forms.

Two register numbers double as constant generators. Register 3 never reads its contents as a source and yields a small constant in every mode. Register 2 yields two further constants in its two indirect modes, and acts as a zero base in indexed mode, which gives absolute addressing. Register 0 is the program counter, so post-increment on it returns the extension word as an immediate and steps the counter past it. The decode result is registered, so it appears one clock after the inputs are presented.

Top module: `sad_operand_decoder`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid`, `wb_en`, `src_ext`, `dst_ext` and `ext_words` are 0 and `op_sel` is 0.
- R2: Every decode result appears on the outputs one clock after the inputs are sampled with `in_valid` high; a cycle sampled with `in_valid` low gives `out_valid` 0 and all other outputs 0.
- R3: Mode codes are 0 register, 1 indexed, 2 indirect, 3 post-increment; `op_sel` codes are 0 register, 1 constant, 2 memory, 3 extension word. In mode 0, any register other than 3 gives `op_sel` 0, no extension word, no write-back and `ea_base` 0.
- R4: Source register 3 gives `op_sel` 1 and `const_val` 0x0000, 0x0001, 0x0002 or 0xFFFF for modes 0, 1, 2, 3, with no extension word and no write-back.
- R5: Source register 2 gives `op_sel` 1 with `const_val` 0x0004 in mode 2 and 0x0008 in mode 3, with no extension word and no write-back.
- R6: Indexed mode gives `op_sel` 2, `src_ext` 1 and `ea_base` equal to the register contents, except that register 2 gives `ea_base` 0 (absolute address).
- R7: Indirect mode on registers 0, 1 and 4 to 15 gives `op_sel` 2, `ea_base` equal to the register contents, no extension word and no write-back.
- R8: Post-increment on registers 1 and 4 to 15 gives `op_sel` 2, `ea_base` equal to the register contents, `wb_en` 1, `wb_reg` equal to the source register and `wb_val` equal to the contents plus 1 for a byte or plus 2 for a word (modulo 2^16); register 1 always steps by 2.
- R9: Post-increment on register 0 gives `op_sel` 3, `src_ext` 1, `ea_base` equal to the counter, and writes back the counter plus 2 for byte and word alike.
- R10: A register destination gives `dst_ext` 0 and `dst_base` 0; an indexed destination gives `dst_ext` 1 and `dst_base` equal to the destination register contents, or 0 when the destination register is 2.
- R11: When an indexed destination names the register that the source post-increments, `dst_base` is the incremented value.
- R12: `ext_words` equals the count of `src_ext` and `dst_ext` that are set (0, 1 or 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| src_reg | input | 4 | Source register number |
| src_mode | input | 2 | Source mode field |
| byte_op | input | 1 | 1 for a byte access, 0 for a word access |
| src_val | input | 16 | Current contents of the source register |
| dst_reg | input | 4 | Destination register number |
| dst_indexed | input | 1 | 1 for an indexed destination, 0 for a register destination |
| dst_val | input | 16 | Current contents of the destination register |
| out_valid | output | 1 | Decode result is valid |
| op_sel | output | 2 | Source operand select code |
| const_val | output | 16 | Generated constant when `op_sel` is 1 |
| src_ext | output | 1 | Source needs an extension word |
| ea_base | output | 16 | Source effective-address base |
| wb_en | output | 1 | Write back a post-incremented register |
| wb_reg | output | 4 | Register to write back |
| wb_val | output | 16 | Value to write back |
| dst_ext | output | 1 | Destination needs an extension word |
| dst_base | output | 16 | Destination effective-address base |
| ext_words | output | 2 | Total extension words for the instruction |

## Verification
The block keeps no state beyond its output register, so any wrong decode shows on the ports exactly one clock after the offending inputs and in no later cycle. A wrong constant or misclassified register number shows as the wrong `op_sel` or `const_val`. A wrong increment step shows in `wb_val` against `ea_base`. A missing forward shows as a `dst_base` that is stale by one or two. A slip in the valid pipeline shows as `out_valid` or cleared outputs landing in the wrong cycle.

// File: rtl/sad_pkg.sv
package sad_pkg;

    localparam int DW = 16;
    localparam int RW = 4;

    typedef logic [DW-1:0] word_t;
    typedef logic [RW-1:0] rid_t;

    typedef enum logic [1:0] {
        SEL_REG   = 2'd0,
        SEL_CONST = 2'd1,
        SEL_MEM   = 2'd2,
        SEL_EXT   = 2'd3
    } opsel_e;

    typedef enum logic [1:0] {
        AM_REG = 2'd0,
        AM_IDX = 2'd1,
        AM_IND = 2'd2,
        AM_INC = 2'd3
    } amode_e;

    // Architectural roles of the low register numbers
    localparam rid_t PC_ID = rid_t'(0);
    localparam rid_t SP_ID = rid_t'(1);
    localparam rid_t SR_ID = rid_t'(2);
    localparam rid_t CG_ID = rid_t'(3);

    localparam word_t STEP_BYTE = word_t'(1);
    localparam word_t STEP_WORD = word_t'(2);

    typedef struct packed {
        opsel_e sel;
        word_t  cval;
        logic   ext;
        word_t  base;
        logic   wb;
        rid_t   wb_id;
        word_t  wb_val;
    } src_dec_t;

    typedef struct packed {
        logic  ext;
        word_t base;
    } dst_dec_t;

    // Registers that keep word alignment step by 2 whatever the access size
    function automatic word_t inc_step(input rid_t id, input logic is_byte);
        if (is_byte && id != PC_ID && id != SP_ID)
            return STEP_BYTE;
        return STEP_WORD;
    endfunction

    // True when the register/mode pair yields a hardwired constant
    function automatic logic cg_hit(input rid_t id, input amode_e m);
        if (id == CG_ID)
            return 1'b1;
        if (id == SR_ID && (m == AM_IND || m == AM_INC))
            return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/sad_const_gen.sv
module sad_const_gen
    import sad_pkg::*;
(
    input  rid_t   id,
    input  amode_e mode,
    output logic   hit,
    output word_t  value
);

    word_t cg3_val;
    word_t cg2_val;

    always_comb begin
        unique case (mode)
            AM_REG: cg3_val = word_t'(0);
            AM_IDX: cg3_val = word_t'(1);
            AM_IND: cg3_val = word_t'(2);
            default: cg3_val = '1;
        endcase
    end

    // Status-register constants exist only for the two indirect codes
    assign cg2_val = (mode == AM_INC) ? word_t'(8) : word_t'(4);

    always_comb begin
        hit   = cg_hit(id, mode);
        value = '0;
        if (hit)
            value = (id == CG_ID) ? cg3_val : cg2_val;
    end

endmodule

// File: rtl/sad_src_decode.sv
module sad_src_decode
    import sad_pkg::*;
(
    input  rid_t     id,
    input  amode_e   mode,
    input  logic     is_byte,
    input  word_t    val,
    output src_dec_t dec
);

    logic  k_hit;
    word_t k_val;

    sad_const_gen u_cg (
        .id    (id),
        .mode  (mode),
        .hit   (k_hit),
        .value (k_val)
    );

    always_comb begin
        dec = '0;
        if (k_hit) begin
            dec.sel  = SEL_CONST;
            dec.cval = k_val;
        end else begin
            unique case (mode)
                AM_REG: begin
                    dec.sel = SEL_REG;
                end
                AM_IDX: begin
                    dec.sel  = SEL_MEM;
                    dec.ext  = 1'b1;
                    dec.base = (id == SR_ID) ? '0 : val;
                end
                AM_IND: begin
                    dec.sel  = SEL_MEM;
                    dec.base = val;
                end
                default: begin
                    dec.base   = val;
                    dec.wb     = 1'b1;
                    dec.wb_id  = id;
                    dec.wb_val = val + inc_step(id, is_byte);
                    if (id == PC_ID) begin
                        dec.sel = SEL_EXT;
                        dec.ext = 1'b1;
                    end else begin
                        dec.sel = SEL_MEM;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/sad_dst_decode.sv
module sad_dst_decode
    import sad_pkg::*;
(
    input  rid_t     id,
    input  logic     indexed,
    input  word_t    val,
    input  logic     fwd_en,
    input  rid_t     fwd_id,
    input  word_t    fwd_val,
    output dst_dec_t dec
);

    word_t cur_val;

    // Source post-increment completes before the destination is addressed
    assign cur_val = (fwd_en && fwd_id == id) ? fwd_val : val;

    always_comb begin
        dec = '0;
        if (indexed) begin
            dec.ext  = 1'b1;
            dec.base = (id == SR_ID) ? '0 : cur_val;
        end
    end

endmodule

// File: rtl/sad_operand_decoder.sv
module sad_operand_decoder
    import sad_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [RW-1:0] src_reg,
    input  logic [1:0]    src_mode,
    input  logic          byte_op,
    input  logic [DW-1:0] src_val,
    input  logic [RW-1:0] dst_reg,
    input  logic          dst_indexed,
    input  logic [DW-1:0] dst_val,
    output logic          out_valid,
    output logic [1:0]    op_sel,
    output logic [DW-1:0] const_val,
    output logic          src_ext,
    output logic [DW-1:0] ea_base,
    output logic          wb_en,
    output logic [RW-1:0] wb_reg,
    output logic [DW-1:0] wb_val,
    output logic          dst_ext,
    output logic [DW-1:0] dst_base,
    output logic [1:0]    ext_words
);

    src_dec_t s_d, s_q;
    dst_dec_t d_d, d_q;
    logic     v_q;

    sad_src_decode u_src (
        .id      (src_reg),
        .mode    (amode_e'(src_mode)),
        .is_byte (byte_op),
        .val     (src_val),
        .dec     (s_d)
    );

    sad_dst_decode u_dst (
        .id      (dst_reg),
        .indexed (dst_indexed),
        .val     (dst_val),
        .fwd_en  (s_d.wb),
        .fwd_id  (s_d.wb_id),
        .fwd_val (s_d.wb_val),
        .dec     (d_d)
    );

    always_ff @(posedge clk) begin
        if (rst || !in_valid) begin
            v_q <= 1'b0;
            s_q <= '0;
            d_q <= '0;
        end else begin
            v_q <= 1'b1;
            s_q <= s_d;
            d_q <= d_d;
        end
    end

    assign out_valid = v_q;
    assign op_sel    = s_q.sel;
    assign const_val = s_q.cval;
    assign src_ext   = s_q.ext;
    assign ea_base   = s_q.base;
    assign wb_en     = s_q.wb;
    assign wb_reg    = s_q.wb_id;
    assign wb_val    = s_q.wb_val;
    assign dst_ext   = d_q.ext;
    assign dst_base  = d_q.base;
    assign ext_words = {1'b0, s_q.ext} + {1'b0, d_q.ext};

endmodule

// File: rtl/sad_operand_decoder_chk.sv
module sad_operand_decoder_chk
    import sad_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [1:0]    op_sel,
    input logic          src_ext,
    input logic [DW-1:0] ea_base,
    input logic          wb_en,
    input logic [RW-1:0] wb_reg,
    input logic [DW-1:0] wb_val,
    input logic          dst_ext,
    input logic [1:0]    ext_words
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!wb_en && !src_ext && !dst_ext && op_sel == 2'd0));

    // R4
    const_no_side_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_sel == 2'd1) |-> (!src_ext && !wb_en));

    // R3
    reg_mode_plain_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_sel == 2'd0) |-> (!src_ext && !wb_en && ea_base == '0));

    // R8
    sp_word_step_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && wb_en && wb_reg == SP_ID) |-> (wb_val == ea_base + word_t'(2)));

    // R8
    inc_step_range_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_reg != PC_ID) |->
            (wb_val == ea_base + word_t'(1) || wb_val == ea_base + word_t'(2)));

    // R9
    immediate_form_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && op_sel == 2'd3) |->
            (src_ext && wb_en && wb_reg == PC_ID && wb_val == ea_base + word_t'(2)));

    // R12
    ext_count_chk: assert property (@(posedge clk) disable iff (rst)
        ext_words == ({1'b0, src_ext} + {1'b0, dst_ext}));

endmodule

bind sad_operand_decoder sad_operand_decoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .op_sel    (op_sel),
    .src_ext   (src_ext),
    .ea_base   (ea_base),
    .wb_en     (wb_en),
    .wb_reg    (wb_reg),
    .wb_val    (wb_val),
    .dst_ext   (dst_ext),
    .ext_words (ext_words)
);

// File: tb/sad_operand_decoder_bench.sv
`timescale 1ns/100ps
module sad_operand_decoder_bench;

    typedef struct packed {
        logic [3:0]  sreg;
        logic [1:0]  smode;
        logic        byt;
        logic [15:0] sval;
        logic [3:0]  dreg;
        logic        didx;
        logic [15:0] dval;
        logic [1:0]  e_sel;
        logic [15:0] e_const;
        logic        e_sext;
        logic [15:0] e_ea;
        logic        e_wb;
        logic [15:0] e_wbval;
        logic        e_dext;
        logic [15:0] e_dbase;
        logic [1:0]  e_extw;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R3 plain register source
        '{4'd5, 2'd0, 1'b0, 16'h1234, 4'd6, 1'b0, 16'h0000, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        // R4 register 3 constants
        '{4'd3, 2'd0, 1'b0, 16'hAAAA, 4'd6, 1'b0, 16'h0000, 2'd1, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        '{4'd3, 2'd1, 1'b0, 16'hAAAA, 4'd6, 1'b0, 16'h0000, 2'd1, 16'h0001, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        '{4'd3, 2'd2, 1'b1, 16'hAAAA, 4'd6, 1'b0, 16'h0000, 2'd1, 16'h0002, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        '{4'd3, 2'd3, 1'b0, 16'hAAAA, 4'd6, 1'b0, 16'h0000, 2'd1, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        // R5 register 2 constants
        '{4'd2, 2'd2, 1'b0, 16'h0107, 4'd6, 1'b0, 16'h0000, 2'd1, 16'h0004, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        '{4'd2, 2'd3, 1'b0, 16'h0107, 4'd6, 1'b0, 16'h0000, 2'd1, 16'h0008, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        // R3 register 2 read as a plain register
        '{4'd2, 2'd0, 1'b0, 16'h0107, 4'd6, 1'b0, 16'h0000, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        // R6 indexed, then absolute with indexed destination
        '{4'd7, 2'd1, 1'b0, 16'h9000, 4'd6, 1'b0, 16'h0000, 2'd2, 16'h0000, 1'b1, 16'h9000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd1},
        '{4'd2, 2'd1, 1'b0, 16'h0107, 4'd6, 1'b1, 16'h9000, 2'd2, 16'h0000, 1'b1, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h9000, 2'd2},
        // R7 indirect
        '{4'd7, 2'd2, 1'b0, 16'h9000, 4'd6, 1'b0, 16'h0000, 2'd2, 16'h0000, 1'b0, 16'h9000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'd0},
        // R8 post-increment word, byte, stack pointer byte
        '{4'd7, 2'd3, 1'b0, 16'h9000, 4'd6, 1'b0, 16'h0000, 2'd2, 16'h0000, 1'b0, 16'h9000, 1'b1, 16'h9002, 1'b0, 16'h0000, 2'd0},
        '{4'd7, 2'd3, 1'b1, 16'h9000, 4'd6, 1'b0, 16'h0000, 2'd2, 16'h0000, 1'b0, 16'h9000, 1'b1, 16'h9001, 1'b0, 16'h0000, 2'd0},
        '{4'd1, 2'd3, 1'b1, 16'h0200, 4'd6, 1'b0, 16'h0000, 2'd2, 16'h0000, 1'b0, 16'h0200, 1'b1, 16'h0202, 1'b0, 16'h0000, 2'd0},
        // R9 immediate, byte flag set
        '{4'd0, 2'd3, 1'b1, 16'hC000, 4'd6, 1'b0, 16'h0000, 2'd3, 16'h0000, 1'b1, 16'hC000, 1'b1, 16'hC002, 1'b0, 16'h0000, 2'd1},
        // R11 forward word step into indexed destination
        '{4'd5, 2'd3, 1'b0, 16'h9000, 4'd5, 1'b1, 16'h9000, 2'd2, 16'h0000, 1'b0, 16'h9000, 1'b1, 16'h9002, 1'b1, 16'h9002, 2'd1},
        // R10 absolute destination
        '{4'd4, 2'd0, 1'b0, 16'h5555, 4'd2, 1'b1, 16'h0107, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'h0000, 2'd1},
        // R12 two extension words, no forward across different registers
        '{4'd0, 2'd3, 1'b0, 16'hC000, 4'd8, 1'b1, 16'h4000, 2'd3, 16'h0000, 1'b1, 16'hC000, 1'b1, 16'hC002, 1'b1, 16'h4000, 2'd2},
        // R11 forward byte step
        '{4'd9, 2'd3, 1'b1, 16'h0011, 4'd9, 1'b1, 16'h0011, 2'd2, 16'h0000, 1'b0, 16'h0011, 1'b1, 16'h0012, 1'b1, 16'h0012, 2'd1},
        // R8 wrap at the top of the address space
        '{4'd6, 2'd3, 1'b0, 16'hFFFF, 4'd6, 1'b0, 16'h0000, 2'd2, 16'h0000, 1'b0, 16'hFFFF, 1'b1, 16'h0001, 1'b0, 16'h0000, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  src_reg;
    logic [1:0]  src_mode;
    logic        byte_op;
    logic [15:0] src_val;
    logic [3:0]  dst_reg;
    logic        dst_indexed;
    logic [15:0] dst_val;
    logic        out_valid;
    logic [1:0]  op_sel;
    logic [15:0] const_val;
    logic        src_ext;
    logic [15:0] ea_base;
    logic        wb_en;
    logic [3:0]  wb_reg;
    logic [15:0] wb_val;
    logic        dst_ext;
    logic [15:0] dst_base;
    logic [1:0]  ext_words;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    sad_operand_decoder u_sad_operand_decoder (
        .clk, .rst, .in_valid, .src_reg, .src_mode, .byte_op, .src_val,
        .dst_reg, .dst_indexed, .dst_val, .out_valid, .op_sel, .const_val,
        .src_ext, .ea_base, .wb_en, .wb_reg, .wb_val, .dst_ext, .dst_base,
        .ext_words
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid    = vld;
        src_reg     = v.sreg;
        src_mode    = v.smode;
        byte_op     = v.byt;
        src_val     = v.sval;
        dst_reg     = v.dreg;
        dst_indexed = v.didx;
        dst_val     = v.dval;
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " out_valid"}, 16'(out_valid), 16'h0);
        chk({tag, " op_sel"},    16'(op_sel),    16'h0);
        chk({tag, " wb_en"},     16'(wb_en),     16'h0);
        chk({tag, " src_ext"},   16'(src_ext),   16'h0);
        chk({tag, " dst_ext"},   16'(dst_ext),   16'h0);
        chk({tag, " ext_words"}, 16'(ext_words), 16'h0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(VECS[9], 1'b1);
        repeat (3) @(negedge clk);
        // R1 outputs cleared under reset even with a valid request present
        check_idle("R1 in reset");
        rst = 1'b0;
        drive(VECS[9], 1'b0);
        @(negedge clk);
        check_idle("R1 after reset");

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            chk($sformatf("R2/R3-R12 v%0d out_valid", i), 16'(out_valid), 16'h1);
            chk($sformatf("R3-R9 v%0d op_sel", i),        16'(op_sel),    16'(VECS[i].e_sel));
            chk($sformatf("R4/R5 v%0d const_val", i),     const_val,      VECS[i].e_const);
            chk($sformatf("R6/R9 v%0d src_ext", i),       16'(src_ext),   16'(VECS[i].e_sext));
            chk($sformatf("R6-R9 v%0d ea_base", i),       ea_base,        VECS[i].e_ea);
            chk($sformatf("R8/R9 v%0d wb_en", i),         16'(wb_en),     16'(VECS[i].e_wb));
            chk($sformatf("R8/R9 v%0d wb_reg", i),        16'(wb_reg),
                VECS[i].e_wb ? 16'(VECS[i].sreg) : 16'h0);
            chk($sformatf("R8/R9 v%0d wb_val", i),        wb_val,         VECS[i].e_wbval);
            chk($sformatf("R10 v%0d dst_ext", i),         16'(dst_ext),   16'(VECS[i].e_dext));
            chk($sformatf("R10/R11 v%0d dst_base", i),    dst_base,       VECS[i].e_dbase);
            chk($sformatf("R12 v%0d ext_words", i),       16'(ext_words), 16'(VECS[i].e_extw));
        end

        // R2 an invalid cycle clears the result one clock later
        drive(VECS[17], 1'b0);
        @(negedge clk);
        check_idle("R2 idle");

        // R2 one clock of latency: valid pulse then idle
        drive(VECS[14], 1'b1);
        @(negedge clk);
        chk("R2 pulse op_sel", 16'(op_sel), 16'd3);
        drive(VECS[14], 1'b0);
        @(negedge clk);
        check_idle("R2 pulse end");

        // R1 reset in the middle of traffic
        drive(VECS[17], 1'b1);
        @(negedge clk);
        chk("R12 pre-reset ext_words", 16'(ext_words), 16'd2);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R1 mid reset");
        rst = 1'b0;
        @(negedge clk);
        chk("R2 resume ext_words", 16'(ext_words), 16'd2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule